// File: doc/BRIEF.md
# Carrier Sense and Collision Generator

This block drives the carrier-sense and collision outputs that an Ethernet PHY presents on its MII toward the MAC. It runs entirely on one internal clock. Receive activity comes from one of two sources, chosen by the speed control. At 10 Mb/s it is a ready-made unsquelched-receive flag. At 100 Mb/s it is derived here by watching the serial stream of received code bits.

A 100 Mb/s receive starts when the most recent ten code bits hold two zeros with at least one bit between them. It ends after a run of ten ones, which is line idle. The receive activity is then combined with the MAC's transmit enable according to the duplex and repeater controls. In half duplex at 10 Mb/s, a timer also produces the heartbeat (SQE test) pulse on the collision output after each transmission. A control bit can suppress that pulse.

The mode controls, transmit enable and unsquelched flag pass through one register stage. The 100 Mb/s scanner registers its result directly. The output stage then registers both outputs. As a result, each output reflects the inputs sampled one clock edge earlier.

Top module: `mii_crs_col`

## Requirements
- R1: While `rst` is high, `crs` and `col` are driven low. Both stay low after reset until activity is seen.
- R2: With `sel_100m`=1, receive activity is raised at the edge that samples a code bit. The condition is that this bit and the nine before it contain two zeros whose bit positions differ by two or more. A pair of adjacent zeros surrounded by ones does not raise activity.
- R3: With `sel_100m`=1, 100 Mb/s receive activity ends at the edge that samples the tenth consecutive one on `code_bit`.
- R4: With `sel_100m`=0, receive activity equals `sq10_active` as sampled at the previous edge.
- R5: With `fdx_mode`=0 and `rptr_mode`=0, `crs` is high when receive activity or `tx_en` is high.
- R6: With `fdx_mode`=1 or `rptr_mode`=1, `crs` follows receive activity only, and `tx_en` has no effect on it.
- R7: With `fdx_mode`=0, `col` is high whenever receive activity and `tx_en` are high together, in both normal and repeater mode.
- R8: With `fdx_mode`=1, `col` stays low under every input pattern.
- R9: Heartbeat pulse. Let edge k be the first edge to sample `tx_en` low after it was high, with `sel_100m`=0, `fdx_mode`=0 and `hb_inhibit`=0. Then `col` is high after edges k+HB_DELAY+2 through k+HB_DELAY+HB_WIDTH+1. A return of `tx_en` high, or a mode change, cancels the pulse.
- R10: No heartbeat pulse is produced when `hb_inhibit`=1 or when `sel_100m`=1.
- R11: Both outputs are registers. A change at the inputs appears on `crs`/`col` one clock edge after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rst | input | 1 | synchronous active-high reset |
| tx_en | input | 1 | transmit enable from the MAC |
| sq10_active | input | 1 | 10 Mb/s unsquelched receive flag |
| code_bit | input | 1 | received 100 Mb/s code bit, one per clock |
| sel_100m | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| fdx_mode | input | 1 | 1 = full duplex |
| rptr_mode | input | 1 | 1 = repeater operation |
| hb_inhibit | input | 1 | 1 = suppress the heartbeat pulse |
| crs | output | 1 | carrier sense |
| col | output | 1 | collision |

## Verification
The bench targets the 100 Mb/s window rule using isolated adjacent zeros versus zeros two apart. A scanner that tests only for "two zeros anywhere" would assert carrier on the adjacent pair. The bench counts the end of idle exactly at nine and ten ones, so an off-by-one idle counter shows up as a crs edge that comes one clock late or early. The heartbeat window is walked cycle by cycle, with inhibit and 100 Mb/s variants. A wrong delay or width moves the collision pulse, and a missing gate puts collision on the line where it must stay quiet. Random mode segments stress full duplex and repeater, where a design that left transmit in the carrier or collision path would show spurious `crs` or `col`.

// File: rtl/mii_cs_pkg.sv
`timescale 1ns/1ps
package mii_cs_pkg;

  typedef struct packed {
    logic sel_100m;
    logic fdx;
    logic rptr;
    logic hb_inh;
  } mode_t;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

endpackage

// File: rtl/rx100_scan.sv
`timescale 1ns/1ps
module rx100_scan #(
  parameter int WIN      = 10,
  parameter int IDLE_RUN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic code_bit,
  output logic active
);
  localparam int OW = $clog2(IDLE_RUN + 1);

  logic [WIN-1:0] win_q, win_d;
  logic [OW-1:0]  ones_q, ones_d;
  logic           hit;

  always_comb begin
    win_d = {win_q[WIN-2:0], code_bit};
    hit   = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      for (int j = 0; j < WIN; j++) begin
        if (j >= i + 2 && !win_d[i] && !win_d[j]) hit = 1'b1;
      end
    end
    if (!code_bit)                     ones_d = '0;
    else if (ones_q == OW'(IDLE_RUN))  ones_d = ones_q;
    else                               ones_d = ones_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '1;
      ones_q <= '0;
      active <= 1'b0;
    end else begin
      win_q  <= win_d;
      ones_q <= ones_d;
      if (hit)                             active <= 1'b1;
      else if (ones_d == OW'(IDLE_RUN))    active <= 1'b0;
    end
  end

  // R3
  idle_end_chk: assert property (@(posedge clk) disable iff (rst)
    (ones_q == OW'(IDLE_RUN) && (&win_q)) |-> !active);

endmodule

// File: rtl/hb_timer.sv
`timescale 1ns/1ps
module hb_timer
  import mii_cs_pkg::*;
#(
  parameter int DELAY = 25,
  parameter int WIDTH = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tx_q,
  output logic pulse
);
  localparam int MAXC = (DELAY > WIDTH) ? DELAY : WIDTH;
  localparam int CW   = $clog2(MAXC + 1);

  hb_state_t      st;
  logic [CW-1:0]  cnt;
  logic           tx_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= HB_IDLE;
      cnt     <= '0;
      tx_prev <= 1'b0;
    end else begin
      tx_prev <= tx_q;
      if (!enable || tx_q) begin
        st  <= HB_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          HB_IDLE: if (tx_prev) begin
            st  <= HB_WAIT;
            cnt <= CW'(DELAY - 1);
          end
          HB_WAIT: if (cnt == '0) begin
            st  <= HB_PULSE;
            cnt <= CW'(WIDTH - 1);
          end else cnt <= cnt - 1'b1;
          HB_PULSE: if (cnt == '0) st <= HB_IDLE;
                    else cnt <= cnt - 1'b1;
          default: st <= HB_IDLE;
        endcase
      end
    end
  end

  assign pulse = (st == HB_PULSE);

  // R10
  hb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pulse);

  // R9
  hb_tx_abort_chk: assert property (@(posedge clk) disable iff (rst)
    tx_q |=> !pulse);

endmodule

// File: rtl/crs_col_out.sv
`timescale 1ns/1ps
module crs_col_out
  import mii_cs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  input  logic  rx_act,
  input  logic  tx_act,
  input  logic  hb,
  output logic  crs,
  output logic  col
);
  logic crs_d, col_d;

  always_comb begin
    crs_d = (mode.fdx || mode.rptr) ? rx_act : (rx_act || tx_act);
    col_d = !mode.fdx && ((rx_act && tx_act) || hb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crs <= 1'b0;
      col <= 1'b0;
    end else begin
      crs <= crs_d;
      col <= col_d;
    end
  end

  // R8
  fdx_col_low_chk: assert property (@(posedge clk) disable iff (rst)
    mode.fdx |=> !col);

  // R5
  half_tx_crs_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode.fdx && !mode.rptr && tx_act) |=> crs);

  // R6
  rx_only_crs_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode.fdx || mode.rptr) && !rx_act) |=> !crs);

endmodule

// File: rtl/mii_crs_col.sv
`timescale 1ns/1ps
module mii_crs_col
  import mii_cs_pkg::*;
#(
  parameter int WIN      = 10,
  parameter int IDLE_RUN = 10,
  parameter int HB_DELAY = 25,
  parameter int HB_WIDTH = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic sq10_active,
  input  logic code_bit,
  input  logic sel_100m,
  input  logic fdx_mode,
  input  logic rptr_mode,
  input  logic hb_inhibit,
  output logic crs,
  output logic col
);
  mode_t mode_q;
  logic  tx_q, sq_q, act100, rx_act, hb_en, hb_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      tx_q   <= 1'b0;
      sq_q   <= 1'b0;
    end else begin
      mode_q <= '{sel_100m: sel_100m, fdx: fdx_mode, rptr: rptr_mode, hb_inh: hb_inhibit};
      tx_q   <= tx_en;
      sq_q   <= sq10_active;
    end
  end

  rx100_scan #(.WIN(WIN), .IDLE_RUN(IDLE_RUN)) u_scan (
    .clk(clk), .rst(rst), .code_bit(code_bit), .active(act100)
  );

  assign rx_act = mode_q.sel_100m ? act100 : sq_q;
  assign hb_en  = !mode_q.sel_100m && !mode_q.fdx && !mode_q.hb_inh;

  hb_timer #(.DELAY(HB_DELAY), .WIDTH(HB_WIDTH)) u_hb (
    .clk(clk), .rst(rst), .enable(hb_en), .tx_q(tx_q), .pulse(hb_pulse)
  );

  crs_col_out u_out (
    .clk(clk), .rst(rst), .mode(mode_q), .rx_act(rx_act), .tx_act(tx_q),
    .hb(hb_pulse), .crs(crs), .col(col)
  );

  // R7
  coll_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q.fdx && rx_act && tx_q) |=> col);

endmodule

// File: tb/test_mii_crs_col.sv
`timescale 1ns/1ps
module test_mii_crs_col;
  localparam int D = 25;
  localparam int W = 25;

  logic clk = 1'b0;
  logic rst, tx_en, sq10_active, code_bit, sel_100m, fdx_mode, rptr_mode, hb_inhibit;
  logic crs, col;
  int   nchk = 0, nfail = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  mii_crs_col #(.HB_DELAY(D), .HB_WIDTH(W)) i_mii_crs_col (
    .clk(clk), .rst(rst), .tx_en(tx_en), .sq10_active(sq10_active), .code_bit(code_bit),
    .sel_100m(sel_100m), .fdx_mode(fdx_mode), .rptr_mode(rptr_mode), .hb_inhibit(hb_inhibit),
    .crs(crs), .col(col)
  );

  // reference state
  logic [9:0] mw;
  int   mones, mst, mcnt;
  logic ma100, mr10, mtx, mprev, msp, mfd, mrp, minh, mcrs, mcol;
  string crs_tag, col_tag;

  function automatic logic two_apart(logic [9:0] w);
    int lo = -1, hi = -1;
    for (int i = 0; i < 10; i++) if (!w[i]) begin
      if (lo < 0) lo = i;
      hi = i;
    end
    return (lo >= 0) && (hi - lo >= 2);
  endfunction

  task automatic model_step();
    logic rx, en, na;
    logic [9:0] w2;
    int ones2, nst, ncnt;
    if (rst) begin
      mw = '1; mones = 0; mst = 0; mcnt = 0;
      {ma100, mr10, mtx, mprev, msp, mfd, mrp, minh, mcrs, mcol} = '0;
      crs_tag = "R1"; col_tag = "R1";
      return;
    end
    rx = msp ? ma100 : mr10;
    mcrs = (mfd || mrp) ? rx : (rx || mtx);
    mcol = !mfd && ((rx && mtx) || (mst == 2));
    crs_tag = (mfd || mrp) ? "R6" : "R5";
    col_tag = mfd ? "R8" : ((mst == 2 && !(rx && mtx)) ? "R9" : "R7");
    en = !msp && !mfd && !minh;
    nst = mst; ncnt = mcnt;
    if (!en || mtx) begin nst = 0; ncnt = 0; end
    else if (mst == 0) begin if (mprev) begin nst = 1; ncnt = D - 1; end end
    else if (mst == 1) begin if (mcnt == 0) begin nst = 2; ncnt = W - 1; end else ncnt = mcnt - 1; end
    else begin if (mcnt == 0) nst = 0; else ncnt = mcnt - 1; end
    mprev = mtx; mst = nst; mcnt = ncnt;
    w2 = {mw[8:0], code_bit};
    ones2 = code_bit ? ((mones < 10) ? mones + 1 : 10) : 0;
    if (two_apart(w2)) na = 1'b1; else if (ones2 >= 10) na = 1'b0; else na = ma100;
    mw = w2; mones = ones2; ma100 = na;
    mr10 = sq10_active; mtx = tx_en;
    msp = sel_100m; mfd = fdx_mode; mrp = rptr_mode; minh = hb_inhibit;
  endtask

  task automatic chk(string tag, string what, logic got, logic exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s got %b exp %b", tag, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    model_step();
    chk(crs_tag, "crs", crs, mcrs);
    chk(col_tag, "col", col, mcol);
  endtask

  task automatic send_bit(logic b);
    code_bit = b;
    cyc();
  endtask

  task automatic set_mode(logic s, logic f, logic r, logic i);
    sel_100m = s; fdx_mode = f; rptr_mode = r; hb_inhibit = i;
    repeat (3) cyc();
  endtask

  task automatic hb_walk(string tag, logic expect_pulse);
    tx_en = 1'b1; repeat (4) cyc();
    tx_en = 1'b0; cyc();            // edge k samples tx_en low
    for (int j = 1; j <= D + W + 4; j++) begin
      cyc();
      chk(tag, "heartbeat col", col, expect_pulse && (j >= D + 2) && (j <= D + W + 1));
    end
  endtask

  initial begin
    void'($urandom(32'd7151));
    rst = 1'b1; tx_en = 0; sq10_active = 0; code_bit = 1;
    sel_100m = 0; fdx_mode = 0; rptr_mode = 0; hb_inhibit = 0;
    repeat (4) begin
      cyc();
      chk("R1", "crs in reset", crs, 1'b0);
      chk("R1", "col in reset", col, 1'b0);
    end
    rst = 1'b0;
    repeat (3) cyc();
    chk("R1", "crs after reset", crs, 1'b0);

    // R11 latency, 10 Mb/s half duplex
    tx_en = 1'b1; cyc();
    chk("R11", "crs one edge after sample", crs, 1'b0);
    cyc();
    chk("R11", "crs two edges after sample", crs, 1'b1);
    tx_en = 1'b0; repeat (D + W + 6) cyc();

    // R4 unsquelched flag
    sq10_active = 1'b1; cyc(); cyc();
    chk("R4", "crs follows sq10", crs, 1'b1);
    sq10_active = 1'b0; cyc(); cyc();
    chk("R4", "crs drops with sq10", crs, 1'b0);

    // R2 / R3 at 100 Mb/s
    set_mode(1, 0, 0, 0);
    repeat (12) send_bit(1);
    send_bit(0); send_bit(0);
    repeat (8) send_bit(1);
    chk("R2", "adjacent zeros ignored", crs, 1'b0);
    send_bit(0); send_bit(1); send_bit(0);
    send_bit(1);
    chk("R2", "zeros two apart start carrier", crs, 1'b1);
    repeat (8) send_bit(1);          // nine ones so far
    send_bit(1);                     // tenth one
    chk("R3", "active after nine ones", crs, 1'b1);
    send_bit(1);
    chk("R3", "idle after ten ones", crs, 1'b0);

    // R9 / R10 heartbeat
    set_mode(0, 0, 0, 0);
    hb_walk("R9", 1'b1);
    set_mode(0, 0, 0, 1);
    hb_walk("R10", 1'b0);
    set_mode(1, 0, 0, 0);
    hb_walk("R10", 1'b0);

    // R6 / R8 full duplex with transmit
    set_mode(0, 1, 0, 0);
    tx_en = 1; sq10_active = 1; cyc(); cyc();
    chk("R8", "col low in full duplex", col, 1'b0);
    sq10_active = 0; cyc(); cyc();
    chk("R6", "tx not in crs", crs, 1'b0);
    tx_en = 0;

    // R7 repeater collision
    set_mode(0, 0, 1, 0);
    tx_en = 1; sq10_active = 1; cyc(); cyc();
    chk("R7", "col in repeater", col, 1'b1);
    tx_en = 0; sq10_active = 0;

    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      int len = 50 + int'($urandom % 150);
      int zp  = 2 + int'($urandom % 12);
      sel_100m   = $urandom % 2;
      fdx_mode   = ($urandom % 3) == 0;
      rptr_mode  = ($urandom % 4) == 0;
      hb_inhibit = ($urandom % 4) == 0;
      if (seg % 13 == 5) begin rst = 1'b1; cyc(); cyc(); rst = 1'b0; end
      for (int c = 0; c < len; c++) begin
        if ($urandom % 16 == 0) tx_en = ~tx_en;
        if ($urandom % 12 == 0) sq10_active = ~sq10_active;
        code_bit = (int'($urandom % zp) == 0) ? 1'b0 : 1'b1;
        cyc();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog run did not complete got timeout exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule